// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block supervises a processor through a falling and recovering supply. Three digital flags stand in for analog comparators: supply below the warning level, supply below the minimum operating level, and supply below the battery level. Crossing the warning level raises a single interrupt request that carries vector 2Bh. The processor keeps running. Crossing the minimum level holds the core in reset. It also kills every memory enable and pulls a shared open-drain reset line low. Other devices on that line can pull it low as well, and the core then resets too. Crossing the battery level moves the memory supply onto the battery and lowers an active-low power-fail output.

Once every reset source has cleared, the core reset is held for a further fixed power-on delay of 21504 clocks. The active-high reset pin and the external line each restart this delay. A program-load pin is debounced. When it becomes low, the block requests bootstrap loading once. Every asynchronous input passes through a two-flop synchronizer before it is used, so flag changes reach the outputs three clocks later.

Top module: `pwr_fail_seq`

## Requirements
- R1: During and directly after the synchronous `rst`, `core_rst_o` is 1. `warn_irq_o`, `rst_line_drive_o`, `bat_sel_o`, `mem_kill_o` and `boot_req_o` are 0, `pf_n_o` is 1, and `warn_vec_o` reads 8'h2B.
- R2: With `warn_int_en_i`=1, a 0-to-1 change of `cmp_warn_i` produces exactly one single-cycle pulse on `warn_irq_o`. `warn_vec_o` stays 8'h2B and `core_rst_o` stays 0.
- R3: One crossing raises at most one request. Arming returns only after `cmp_warn_i` has gone back to 0. A crossing that occurs while the enable is 0 uses up the arming, and no request follows if the enable is set later during the same crossing.
- R4: While `cmp_min_i` is 1, `core_rst_o`, `mem_kill_o` and `rst_line_drive_o` are all 1. `mem_kill_o` and `rst_line_drive_o` return to 0 once the flag clears.
- R5: A low level on `rst_line_i` caused by another device asserts `core_rst_o`. The block itself leaves `rst_line_drive_o` at 0 in this case.
- R6: `bat_sel_o`=1 and `pf_n_o`=0 while `cmp_bat_i` is 1, and they revert when it clears.
- R7: After the last reset source clears, `core_rst_o` stays 1 for at least 21504 clocks and drops within 21512 clocks of the input change.
- R8: `ext_rst_i`=1, even for a few clocks, asserts `core_rst_o` and restarts the power-on delay. It does not drive the shared line.
- R9: `prog_n_i` counts as low only after 48 consecutive low clocks, and then `boot_req_o` pulses once. A shorter low is ignored. Another request needs 48 consecutive high clocks first.
- R10: A change on `cmp_bat_i` reaches `bat_sel_o` on the third rising edge after the change: it is unchanged two edges later and updated three edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| cmp_warn_i | input | 1 | Supply below warning level |
| cmp_min_i | input | 1 | Supply below minimum operating level |
| cmp_bat_i | input | 1 | Supply below battery level |
| warn_int_en_i | input | 1 | Warning interrupt enable |
| ext_rst_i | input | 1 | Active-high reset pin |
| rst_line_i | input | 1 | Sensed level of the shared open-drain reset line |
| prog_n_i | input | 1 | Program-load pin, active low |
| warn_irq_o | output | 1 | Warning interrupt request pulse |
| warn_vec_o | output | 8 | Warning interrupt vector address |
| core_rst_o | output | 1 | Internal processor reset |
| rst_line_drive_o | output | 1 | 1 pulls the shared reset line low |
| bat_sel_o | output | 1 | 1 selects battery as memory supply |
| pf_n_o | output | 1 | Active-low power-fail indication |
| mem_kill_o | output | 1 | Forces all memory enables and write inactive |
| boot_req_o | output | 1 | Bootstrap load request pulse |

## Verification
The hardest case to reach is the exact release of the power-on delay when the block's own drive of the shared line feeds back through the line sense. The bench models the line as a wired-AND of the design's drive and a bench pull. Releasing `cmp_min_i` therefore first drops the drive, then the line recovers, and only then does the delay start. The bench counts clocks from the flag change to the fall of `core_rst_o` and checks that the count falls in the required window. The warning re-arm rule is reached by holding the flag across an enable change and then toggling it, with the pulses counted on every clock.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int unsigned POR_CYCLES_DEF = 21504;
  localparam int unsigned PROG_FILT_DEF  = 48;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam logic [7:0]  WARN_VEC_DEF   = 8'h2B;

  typedef struct packed {
    logic ext;
    logic line_low;
    logic bat;
    logic min;
    logic warn;
  } flags_t;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pfs_por_timer.sv
module pfs_por_timer #(
  parameter int unsigned CYCLES = 21504
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q  <= '0;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt_q == CW'(CYCLES - 1)) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: the counter is only running while the delay is in progress
  p_idle_cnt_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> cnt_q == '0);
endmodule

// File: rtl/pfs_pin_filter.sv
module pfs_pin_filter #(
  parameter int unsigned FILT   = 48,
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic req_o
);
  localparam int unsigned CW = $clog2(FILT);
  logic          pin_s;
  logic          level_q;
  logic [CW-1:0] cnt_q;

  pfs_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_n_i),
    .q_o (pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
      req_o   <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (pin_s == level_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT - 1)) begin
        cnt_q   <= '0;
        level_q <= pin_s;
        req_o   <= ~pin_s;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_boot_single_r9: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);
  p_boot_on_low_r9: assert property (@(posedge clk) disable iff (rst)
    req_o |-> !level_q);
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq
  import pfs_pkg::*;
#(
  parameter int unsigned POR_CYCLES = POR_CYCLES_DEF,
  parameter int unsigned PROG_FILT  = PROG_FILT_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  parameter logic [7:0]  WARN_VEC   = WARN_VEC_DEF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmp_warn_i,
  input  logic       cmp_min_i,
  input  logic       cmp_bat_i,
  input  logic       warn_int_en_i,
  input  logic       ext_rst_i,
  input  logic       rst_line_i,
  input  logic       prog_n_i,
  output logic       warn_irq_o,
  output logic [7:0] warn_vec_o,
  output logic       core_rst_o,
  output logic       rst_line_drive_o,
  output logic       bat_sel_o,
  output logic       pf_n_o,
  output logic       mem_kill_o,
  output logic       boot_req_o
);
  localparam int unsigned QW = $clog2(POR_CYCLES + 1);

  flags_t raw, syn;
  logic   rst_src;
  logic   por_busy;
  logic   warn_armed_q;
  logic [QW-1:0] quiet_q;

  always_comb begin
    raw.warn     = cmp_warn_i;
    raw.min      = cmp_min_i;
    raw.bat      = cmp_bat_i;
    raw.line_low = ~rst_line_i;
    raw.ext      = ext_rst_i;
  end

  pfs_sync #(.W($bits(flags_t)), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_flag_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (syn)
  );

  assign rst_src = syn.min | syn.line_low | syn.ext;

  pfs_por_timer #(.CYCLES(POR_CYCLES)) u_por (
    .clk    (clk),
    .rst    (rst),
    .hold_i (rst_src),
    .busy_o (por_busy)
  );

  pfs_pin_filter #(.FILT(PROG_FILT), .STAGES(SYNC_DEPTH)) u_prog (
    .clk     (clk),
    .rst     (rst),
    .pin_n_i (prog_n_i),
    .req_o   (boot_req_o)
  );

  // supply-level outputs, all registered
  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst_o       <= 1'b1;
      rst_line_drive_o <= 1'b0;
      mem_kill_o       <= 1'b0;
      bat_sel_o        <= 1'b0;
      pf_n_o           <= 1'b1;
      warn_vec_o       <= WARN_VEC;
    end else begin
      core_rst_o       <= rst_src | por_busy;
      rst_line_drive_o <= syn.min;
      mem_kill_o       <= syn.min;
      bat_sel_o        <= syn.bat;
      pf_n_o           <= ~syn.bat;
      warn_vec_o       <= WARN_VEC;
    end
  end

  // warning request: one pulse per crossing, re-armed when the flag clears
  always_ff @(posedge clk) begin
    if (rst) begin
      warn_armed_q <= 1'b1;
      warn_irq_o   <= 1'b0;
    end else begin
      warn_irq_o <= 1'b0;
      if (!syn.warn) begin
        warn_armed_q <= 1'b1;
      end else if (warn_armed_q) begin
        warn_armed_q <= 1'b0;
        warn_irq_o   <= warn_int_en_i;
      end
    end
  end

  // independent count of quiet cycles since a reset source was last seen
  always_ff @(posedge clk) begin
    if (rst || rst_src)                 quiet_q <= '0;
    else if (quiet_q != QW'(POR_CYCLES)) quiet_q <= quiet_q + 1'b1;
  end

  p_kill_in_rst_r4: assert property (@(posedge clk) disable iff (rst)
    mem_kill_o |-> core_rst_o);
  p_drive_in_rst_r4: assert property (@(posedge clk) disable iff (rst)
    rst_line_drive_o |-> core_rst_o);
  p_por_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> quiet_q >= QW'(POR_CYCLES));
  p_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
    warn_irq_o |=> !warn_irq_o);
  p_bat_pf_r6: assert property (@(posedge clk) disable iff (rst)
    bat_sel_o != pf_n_o);
  p_vec_const_r2: assert property (@(posedge clk) disable iff (rst)
    warn_irq_o |-> warn_vec_o == WARN_VEC);
endmodule

// File: tb/test_pwr_fail_seq.sv
`timescale 1ns/1ps
module test_pwr_fail_seq;
  localparam int POR = 21504;
  localparam time TCLK = 20ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_warn = 0, cmp_min = 0, cmp_bat = 0, warn_en = 1, ext_rst = 0;
  logic ext_pull = 0, prog_n = 1;
  logic rst_line;
  logic warn_irq, core_rst, line_drive, bat_sel, pf_n, mem_kill, boot_req;
  logic [7:0] warn_vec;
  int checks = 0, fails = 0;
  int irq_cnt = 0, boot_cnt = 0;

  always #(TCLK/2) clk = ~clk;
  assign rst_line = !(line_drive || ext_pull);

  pwr_fail_seq i_pwr_fail_seq (
    .clk(clk), .rst(rst), .cmp_warn_i(cmp_warn), .cmp_min_i(cmp_min),
    .cmp_bat_i(cmp_bat), .warn_int_en_i(warn_en), .ext_rst_i(ext_rst),
    .rst_line_i(rst_line), .prog_n_i(prog_n), .warn_irq_o(warn_irq),
    .warn_vec_o(warn_vec), .core_rst_o(core_rst), .rst_line_drive_o(line_drive),
    .bat_sel_o(bat_sel), .pf_n_o(pf_n), .mem_kill_o(mem_kill), .boot_req_o(boot_req)
  );

  always @(negedge clk) begin
    if (warn_irq) irq_cnt++;
    if (boot_req) boot_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (core_rst && n < 30000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    int n;
    wait_neg(4);
    chk(core_rst == 1, "R1 core_rst", core_rst, 1);
    chk({warn_irq, line_drive, bat_sel, mem_kill, boot_req} == 0, "R1 outputs idle",
        {warn_irq, line_drive, bat_sel, mem_kill, boot_req}, 0);
    chk(pf_n == 1, "R1 pf_n", pf_n, 1);
    chk(warn_vec == 8'h2B, "R1 vector", warn_vec, 8'h2B);
    @(negedge clk) rst = 0;
    wait_release(n);
    chk(n >= POR && n <= POR + 8, "R7 delay after block reset", n, POR);
  endtask

  task automatic t_warn;
    int c0 = irq_cnt;
    warn_en = 1; cmp_warn = 1;
    wait_neg(2);
    chk(warn_vec == 8'h2B, "R2 vector", warn_vec, 8'h2B);
    wait_neg(10);
    chk(irq_cnt - c0 == 1, "R2 single pulse", irq_cnt - c0, 1);
    chk(core_rst == 0, "R2 no reset", core_rst, 0);
    wait_neg(20);
    chk(irq_cnt - c0 == 1, "R3 no repeat while below", irq_cnt - c0, 1);
    cmp_warn = 0; wait_neg(6); cmp_warn = 1; wait_neg(8);
    chk(irq_cnt - c0 == 2, "R3 re-armed after clear", irq_cnt - c0, 2);
    cmp_warn = 0; wait_neg(6);
  endtask

  task automatic t_warn_disabled;
    int c0 = irq_cnt;
    warn_en = 0; cmp_warn = 1; wait_neg(8);
    chk(irq_cnt - c0 == 0, "R3 disabled crossing", irq_cnt - c0, 0);
    warn_en = 1; wait_neg(8);
    chk(irq_cnt - c0 == 0, "R3 enable late in crossing", irq_cnt - c0, 0);
    cmp_warn = 0; wait_neg(6); cmp_warn = 1; wait_neg(8);
    chk(irq_cnt - c0 == 1, "R3 next crossing", irq_cnt - c0, 1);
    cmp_warn = 0; wait_neg(6);
  endtask

  task automatic t_bat;
    cmp_bat = 1; wait_neg(2);
    chk(bat_sel == 0, "R10 unchanged at 2 edges", bat_sel, 0);
    wait_neg(1);
    chk(bat_sel == 1, "R10 updated at 3 edges", bat_sel, 1);
    chk(pf_n == 0, "R6 pf_n low", pf_n, 0);
    chk(core_rst == 0, "R6 no reset from battery flag", core_rst, 0);
    cmp_bat = 0; wait_neg(4);
    chk(bat_sel == 0 && pf_n == 1, "R6 revert", {bat_sel, pf_n}, 1);
  endtask

  task automatic t_min;
    int n;
    cmp_min = 1; wait_neg(5);
    chk(core_rst && mem_kill && line_drive, "R4 reset/kill/drive",
        {core_rst, mem_kill, line_drive}, 7);
    wait_neg(100);
    chk(core_rst && mem_kill, "R4 held while low", {core_rst, mem_kill}, 3);
    cmp_min = 0; wait_neg(4);
    chk(!mem_kill && !line_drive, "R4 kill/drive clear", {mem_kill, line_drive}, 0);
    chk(core_rst == 1, "R7 still in delay", core_rst, 1);
    wait_release(n);
    n += 4;
    chk(n >= POR && n <= POR + 8, "R7 release window", n, POR);
  endtask

  task automatic t_line;
    int n;
    ext_pull = 1; wait_neg(6);
    chk(core_rst == 1, "R5 external line low resets", core_rst, 1);
    chk(line_drive == 0, "R5 no self drive", line_drive, 0);
    ext_pull = 0;
    wait_release(n);
    chk(n >= POR && n <= POR + 8, "R5 release after line", n, POR);
  endtask

  task automatic t_ext;
    int n;
    ext_rst = 1; wait_neg(3); ext_rst = 0; wait_neg(3);
    chk(core_rst == 1, "R8 pin reset", core_rst, 1);
    chk(line_drive == 0, "R8 no line drive", line_drive, 0);
    wait_release(n);
    n += 3;
    chk(n >= POR && n <= POR + 8, "R8 delay restarted", n, POR);
  endtask

  task automatic t_prog;
    int c0 = boot_cnt;
    prog_n = 0; wait_neg(20); prog_n = 1; wait_neg(60);
    chk(boot_cnt - c0 == 0, "R9 short low ignored", boot_cnt - c0, 0);
    prog_n = 0; wait_neg(100);
    chk(boot_cnt - c0 == 1, "R9 long low requests", boot_cnt - c0, 1);
    prog_n = 1; wait_neg(20); prog_n = 0; wait_neg(100);
    chk(boot_cnt - c0 == 1, "R9 short high ignored", boot_cnt - c0, 1);
    prog_n = 1; wait_neg(100); prog_n = 0; wait_neg(100);
    chk(boot_cnt - c0 == 2, "R9 second request", boot_cnt - c0, 2);
    prog_n = 1; wait_neg(60);
  endtask

  initial begin
    #(TCLK * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_warn();
    t_warn_disabled();
    t_bat();
    t_prog();
    t_min();
    t_line();
    t_ext();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule